// File: doc/BRIEF.md
# Flash Cycle Engine

This block lets a host run flash operations by naming an abstract cycle kind instead of a raw flash opcode. The host loads a flash address and up to 64 data bytes into a local buffer. It then writes one control word that holds a cycle code, a byte count and a go bit. The engine builds the complete command sequence on a byte-level SPI master port. It prepends a write-enable frame where the flash needs one, and it polls the flash busy flag after program-class cycles. It then reports the outcome through three sticky status flags.

The SPI side is a simple byte handshake. The engine drives chip select low for a frame and raises `spi_req` with the outgoing byte. The shifter pulses `spi_ack` for one cycle, together with the byte it received. One protected window, an inclusive range given by `prot_lo` and `prot_hi`, stops program and erase cycles from touching the flash at all.

Top module: `flash_cycle_engine`

## Requirements
- R1: After reset all status flags and the control fields read 0, `spi_cs_n` is 1 and `spi_req` is 0.
- R2: Cycle code 0 (read) sends one frame: 0x0B, the address bytes most significant first, one 0x00 dummy byte, then count+1 bytes. The received bytes go to buffer entries 0 upward, and done is set at the end.
- R3: Cycle code 1 (program) sends a frame holding only 0x06. It then sends a frame of 0x02, the address and buffer entries 0 to count, and then busy-polls.
- R4: Cycle code 2 (4 KB erase) sends a 0x06 frame, then a frame of 0x20 and the address only, whatever the count field holds. It then busy-polls.
- R5: Cycle code 3 (read ID) sends a frame of 0x9F followed by count+1 read bytes. Code 5 (read status) does the same with 0x05. Code 4 (write status) sends a 0x06 frame, then 0x01 with buffer entries 0 to count, then busy-polls. Read bytes are stored from buffer entry 0.
- R6: A busy poll is a repeated frame of 0x05 plus one read byte. Polling stops with done as soon as bit 0 of the read byte is 0.
- R7: If POLL_MAX consecutive polled status bytes all have bit 0 set, the cycle ends with the cycle-error flag and without done.
- R8: A program or erase whose address satisfies prot_lo <= address <= prot_hi sets the access-error flag and drives no SPI frame.
- R9: Cycle codes 6 and 7 set the cycle-error flag and drive no SPI frame.
- R10: Control bit 0 reads 1 while a cycle runs. Control and address writes made during that time have no effect.
- R11: Status flags sit at control bits 12 (done), 13 (cycle error) and 14 (access error). They hold until the host writes 1 to them while idle, and that clearing write may also set go.
- R12: The control word has go at bit 0, the cycle code at bits 3:1 and the count (length minus one) at bits 9:4. The code and count fields read back the values of the last accepted go.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| addr_we | input | 1 | Load flash address |
| addr_wdata | input | ADDR_W | Flash address to load |
| prot_lo | input | ADDR_W | Lowest protected address |
| prot_hi | input | ADDR_W | Highest protected address |
| fifo_we | input | 1 | Host write to data buffer |
| fifo_widx | input | log2(FIFO_DEPTH) | Host write entry |
| fifo_wdata | input | 8 | Host write byte |
| fifo_ridx | input | log2(FIFO_DEPTH) | Host read entry |
| fifo_rdata | output | 8 | Host read byte |
| ctl_we | input | 1 | Control/status write strobe |
| ctl_wdata | input | 16 | Control/status write word |
| ctl_rdata | output | 16 | Control/status read word |
| spi_cs_n | output | 1 | Flash chip select, active low |
| spi_req | output | 1 | Byte transfer request |
| spi_tx | output | 8 | Byte to shift out |
| spi_ack | input | 1 | Byte transfer finished (one-cycle pulse) |
| spi_rx | input | 8 | Byte shifted in |

## Verification
A single host write can clear stale status flags and start a new cycle in the same clock. The bench does this on every vector: it writes all three clear bits together with go while the flags left over from the previous vector (done, cycle error or access error) are still set. Each finished cycle must then show exactly its own flag, so a clear that gets lost, or one that wipes out the new result, shows up as a status mismatch. A second overlap is a new go written mid-cycle while the engine is busy. It is judged by checking that the SPI byte stream and the echoed fields still belong to the first cycle.

// File: rtl/fce_pkg.sv
package fce_pkg;

   typedef enum logic [1:0] {
      DIR_NONE = 2'd0,
      DIR_IN   = 2'd1,
      DIR_OUT  = 2'd2
   } dir_e;

   typedef struct packed {
      logic       valid;
      logic [7:0] opcode;
      logic       wren;
      logic       has_addr;
      logic       has_dummy;
      dir_e       dir;
      logic       poll;
      logic       guarded;
   } cyc_plan_t;

   localparam logic [2:0] CODE_READ  = 3'd0;
   localparam logic [2:0] CODE_PROG  = 3'd1;
   localparam logic [2:0] CODE_ERASE = 3'd2;
   localparam logic [2:0] CODE_RDID  = 3'd3;
   localparam logic [2:0] CODE_WRSR  = 3'd4;
   localparam logic [2:0] CODE_RDSR  = 3'd5;

   localparam logic [7:0] OP_WREN  = 8'h06;
   localparam logic [7:0] OP_RDSR  = 8'h05;
   localparam logic [7:0] OP_FREAD = 8'h0B;
   localparam logic [7:0] OP_PROG  = 8'h02;
   localparam logic [7:0] OP_ERASE = 8'h20;
   localparam logic [7:0] OP_RDID  = 8'h9F;
   localparam logic [7:0] OP_WRSR  = 8'h01;

   localparam int CTL_W       = 16;
   localparam int CTL_GO      = 0;
   localparam int CTL_CODE    = 1;
   localparam int CTL_CNT     = 4;
   localparam int CTL_DONE    = 12;
   localparam int CTL_CERR    = 13;
   localparam int CTL_AERR    = 14;

endpackage

// File: rtl/fce_opmap.sv
module fce_opmap
   import fce_pkg::*;
(
   input  logic [2:0] code,
   output cyc_plan_t  plan
);

   always_comb begin
      plan = '0;
      plan.dir = DIR_NONE;
      case (code)
         CODE_READ: begin
            plan.valid     = 1'b1;
            plan.opcode    = OP_FREAD;
            plan.has_addr  = 1'b1;
            plan.has_dummy = 1'b1;
            plan.dir       = DIR_IN;
         end
         CODE_PROG: begin
            plan.valid    = 1'b1;
            plan.opcode   = OP_PROG;
            plan.wren     = 1'b1;
            plan.has_addr = 1'b1;
            plan.dir      = DIR_OUT;
            plan.poll     = 1'b1;
            plan.guarded  = 1'b1;
         end
         CODE_ERASE: begin
            plan.valid    = 1'b1;
            plan.opcode   = OP_ERASE;
            plan.wren     = 1'b1;
            plan.has_addr = 1'b1;
            plan.poll     = 1'b1;
            plan.guarded  = 1'b1;
         end
         CODE_RDID: begin
            plan.valid  = 1'b1;
            plan.opcode = OP_RDID;
            plan.dir    = DIR_IN;
         end
         CODE_WRSR: begin
            plan.valid  = 1'b1;
            plan.opcode = OP_WRSR;
            plan.wren   = 1'b1;
            plan.dir    = DIR_OUT;
            plan.poll   = 1'b1;
         end
         CODE_RDSR: begin
            plan.valid  = 1'b1;
            plan.opcode = OP_RDSR;
            plan.dir    = DIR_IN;
         end
         default: plan.valid = 1'b0;
      endcase
   end

endmodule

// File: rtl/fce_fifo.sv
module fce_fifo #(
   parameter  int DEPTH = 64,
   localparam int IDX_W = $clog2(DEPTH)
) (
   input  logic             clk,
   input  logic             host_we,
   input  logic [IDX_W-1:0] host_widx,
   input  logic [7:0]       host_wdata,
   input  logic [IDX_W-1:0] host_ridx,
   output logic [7:0]       host_rdata,
   input  logic             eng_we,
   input  logic [IDX_W-1:0] eng_idx,
   input  logic [7:0]       eng_wdata,
   output logic [7:0]       eng_rdata
);

   logic [7:0] mem [DEPTH];

   // engine capture wins over a host write to the same entry
   always_ff @(posedge clk) begin
      for (int i = 0; i < DEPTH; i++) begin
         if (eng_we && eng_idx == IDX_W'(i))
            mem[i] <= eng_wdata;
         else if (host_we && host_widx == IDX_W'(i))
            mem[i] <= host_wdata;
      end
   end

   assign host_rdata = mem[host_ridx];
   assign eng_rdata  = mem[eng_idx];

endmodule

// File: rtl/fce_seq.sv
module fce_seq
   import fce_pkg::*;
#(
   parameter  int ADDR_W   = 24,
   parameter  int CNT_W    = 6,
   parameter  int POLL_MAX = 1000,
   localparam int ADDR_BYTES = ADDR_W / 8,
   localparam int AB_W     = (ADDR_BYTES > 1) ? $clog2(ADDR_BYTES) : 1,
   localparam int PC_W     = $clog2(POLL_MAX + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  cyc_plan_t         plan,
   input  logic [CNT_W-1:0]  len_m1,
   input  logic [ADDR_W-1:0] addr,
   input  logic [ADDR_W-1:0] prot_lo,
   input  logic [ADDR_W-1:0] prot_hi,
   input  logic              spi_ack,
   input  logic [7:0]        spi_rx,
   output logic              spi_cs_n,
   output logic              spi_req,
   output logic [7:0]        spi_tx,
   output logic [CNT_W-1:0]  fifo_idx,
   output logic              fifo_we,
   output logic [7:0]        fifo_wdata,
   input  logic [7:0]        fifo_rdata,
   output logic              busy,
   output logic              fin_done,
   output logic              fin_cerr,
   output logic              fin_aerr
);

   typedef enum logic [3:0] {
      S_IDLE, S_WREN, S_WGAP, S_OP, S_ADDR, S_DUMMY, S_DATA,
      S_EGAP, S_PCMD, S_PRD, S_PGAP, S_DONE, S_CERR, S_AERR
   } st_e;

   st_e             state;
   logic [CNT_W-1:0] idx;
   logic [AB_W-1:0]  abyte;
   logic [PC_W-1:0]  pcnt;
   logic [7:0]       addr_bytes [ADDR_BYTES];
   logic             in_frame;
   logic             hit;
   st_e              after_hdr;

   for (genvar b = 0; b < ADDR_BYTES; b++) begin : g_abyte
      assign addr_bytes[b] = addr[ADDR_W-1-8*b -: 8];
   end

   assign hit       = (addr >= prot_lo) && (addr <= prot_hi);
   assign after_hdr = (plan.dir == DIR_NONE) ? S_EGAP : S_DATA;
   assign in_frame  = (state inside {S_WREN, S_OP, S_ADDR, S_DUMMY, S_DATA, S_PCMD, S_PRD});
   assign spi_req   = in_frame;
   assign spi_cs_n  = !in_frame;
   assign busy      = (state != S_IDLE);
   assign fin_done  = (state == S_DONE);
   assign fin_cerr  = (state == S_CERR);
   assign fin_aerr  = (state == S_AERR);
   assign fifo_idx  = idx;
   assign fifo_wdata = spi_rx;
   assign fifo_we   = (state == S_DATA) && spi_ack && (plan.dir == DIR_IN);

   always_comb begin
      case (state)
         S_WREN:  spi_tx = OP_WREN;
         S_OP:    spi_tx = plan.opcode;
         S_ADDR:  spi_tx = addr_bytes[abyte];
         S_DATA:  spi_tx = (plan.dir == DIR_OUT) ? fifo_rdata : 8'h00;
         S_PCMD:  spi_tx = OP_RDSR;
         default: spi_tx = 8'h00;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state <= S_IDLE;
         idx   <= '0;
         abyte <= '0;
         pcnt  <= '0;
      end else begin
         case (state)
            S_IDLE: if (start) begin
               idx   <= '0;
               abyte <= '0;
               pcnt  <= '0;
               if (!plan.valid)              state <= S_CERR;
               else if (plan.guarded && hit) state <= S_AERR;
               else if (plan.wren)           state <= S_WREN;
               else                          state <= S_OP;
            end
            S_WREN: if (spi_ack) state <= S_WGAP;
            S_WGAP: state <= S_OP;
            S_OP: if (spi_ack) state <= plan.has_addr ? S_ADDR : after_hdr;
            S_ADDR: if (spi_ack) begin
               if (abyte == AB_W'(ADDR_BYTES - 1))
                  state <= plan.has_dummy ? S_DUMMY : after_hdr;
               else
                  abyte <= abyte + 1'b1;
            end
            S_DUMMY: if (spi_ack) state <= S_DATA;
            S_DATA: if (spi_ack) begin
               if (idx == len_m1) state <= S_EGAP;
               else               idx   <= idx + 1'b1;
            end
            S_EGAP: state <= plan.poll ? S_PCMD : S_DONE;
            S_PCMD: if (spi_ack) state <= S_PRD;
            S_PRD: if (spi_ack) begin
               if (!spi_rx[0])                      state <= S_DONE;
               else if (pcnt == PC_W'(POLL_MAX - 1)) state <= S_CERR;
               else begin
                  pcnt  <= pcnt + 1'b1;
                  state <= S_PGAP;
               end
            end
            S_PGAP:  state <= S_PCMD;
            default: state <= S_IDLE;
         endcase
      end
   end

endmodule

// File: rtl/flash_cycle_engine.sv
module flash_cycle_engine
   import fce_pkg::*;
#(
   parameter  int ADDR_W     = 24,
   parameter  int FIFO_DEPTH = 64,
   parameter  int POLL_MAX   = 1000,
   localparam int CNT_W      = $clog2(FIFO_DEPTH)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              addr_we,
   input  logic [ADDR_W-1:0] addr_wdata,
   input  logic [ADDR_W-1:0] prot_lo,
   input  logic [ADDR_W-1:0] prot_hi,
   input  logic              fifo_we,
   input  logic [CNT_W-1:0]  fifo_widx,
   input  logic [7:0]        fifo_wdata,
   input  logic [CNT_W-1:0]  fifo_ridx,
   output logic [7:0]        fifo_rdata,
   input  logic              ctl_we,
   input  logic [15:0]       ctl_wdata,
   output logic [15:0]       ctl_rdata,
   output logic              spi_cs_n,
   output logic              spi_req,
   output logic [7:0]        spi_tx,
   input  logic              spi_ack,
   input  logic [7:0]        spi_rx
);

   initial begin
      assert (ADDR_W % 8 == 0 && ADDR_W >= 8)
         else $error("ADDR_W must be a whole number of bytes");
      assert (FIFO_DEPTH >= 2 && (1 << CNT_W) == FIFO_DEPTH)
         else $error("FIFO_DEPTH must be a power of two");
      assert (CNT_W <= CTL_DONE - CTL_CNT)
         else $error("count field overlaps status bits");
      assert (POLL_MAX >= 1)
         else $error("POLL_MAX must be at least 1");
   end

   logic              start_q;
   logic [2:0]        code_q;
   logic [CNT_W-1:0]  cnt_q;
   logic [ADDR_W-1:0] addr_q;
   logic              st_done, st_cerr, st_aerr;
   logic              seq_busy, busy_all, accept, go;
   logic              fin_done, fin_cerr, fin_aerr;
   cyc_plan_t         plan;
   logic [CNT_W-1:0]  eng_idx;
   logic              eng_we;
   logic [7:0]        eng_wdata, eng_rdata;
   logic              unused_ctl;

   assign unused_ctl = ^ctl_wdata;
   assign busy_all   = start_q | seq_busy;
   assign accept     = ctl_we && !busy_all;
   assign go         = accept && ctl_wdata[CTL_GO];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         start_q <= 1'b0;
         code_q  <= '0;
         cnt_q   <= '0;
         addr_q  <= '0;
         st_done <= 1'b0;
         st_cerr <= 1'b0;
         st_aerr <= 1'b0;
      end else begin
         start_q <= go;
         if (go) begin
            code_q <= ctl_wdata[CTL_CODE +: 3];
            cnt_q  <= ctl_wdata[CTL_CNT +: CNT_W];
         end
         if (addr_we && !busy_all) addr_q <= addr_wdata;
         if (fin_done)                              st_done <= 1'b1;
         else if (accept && ctl_wdata[CTL_DONE])    st_done <= 1'b0;
         if (fin_cerr)                              st_cerr <= 1'b1;
         else if (accept && ctl_wdata[CTL_CERR])    st_cerr <= 1'b0;
         if (fin_aerr)                              st_aerr <= 1'b1;
         else if (accept && ctl_wdata[CTL_AERR])    st_aerr <= 1'b0;
      end
   end

   always_comb begin
      ctl_rdata = '0;
      ctl_rdata[CTL_GO]            = busy_all;
      ctl_rdata[CTL_CODE +: 3]     = code_q;
      ctl_rdata[CTL_CNT +: CNT_W]  = cnt_q;
      ctl_rdata[CTL_DONE]          = st_done;
      ctl_rdata[CTL_CERR]          = st_cerr;
      ctl_rdata[CTL_AERR]          = st_aerr;
   end

   fce_opmap u_opmap (
      .code (code_q),
      .plan (plan)
   );

   fce_fifo #(.DEPTH(FIFO_DEPTH)) u_fifo (
      .clk        (clk),
      .host_we    (fifo_we),
      .host_widx  (fifo_widx),
      .host_wdata (fifo_wdata),
      .host_ridx  (fifo_ridx),
      .host_rdata (fifo_rdata),
      .eng_we     (eng_we),
      .eng_idx    (eng_idx),
      .eng_wdata  (eng_wdata),
      .eng_rdata  (eng_rdata)
   );

   fce_seq #(
      .ADDR_W   (ADDR_W),
      .CNT_W    (CNT_W),
      .POLL_MAX (POLL_MAX)
   ) u_seq (
      .clk        (clk),
      .rst_n      (rst_n),
      .start      (start_q),
      .plan       (plan),
      .len_m1     (cnt_q),
      .addr       (addr_q),
      .prot_lo    (prot_lo),
      .prot_hi    (prot_hi),
      .spi_ack    (spi_ack),
      .spi_rx     (spi_rx),
      .spi_cs_n   (spi_cs_n),
      .spi_req    (spi_req),
      .spi_tx     (spi_tx),
      .fifo_idx   (eng_idx),
      .fifo_we    (eng_we),
      .fifo_wdata (eng_wdata),
      .fifo_rdata (eng_rdata),
      .busy       (seq_busy),
      .fin_done   (fin_done),
      .fin_cerr   (fin_cerr),
      .fin_aerr   (fin_aerr)
   );

endmodule

// File: rtl/fce_chk.sv
module fce_chk (
   input logic        clk,
   input logic        rst_n,
   input logic        ctl_we,
   input logic [15:0] ctl_wdata,
   input logic [15:0] ctl_rdata,
   input logic        spi_cs_n,
   input logic        spi_req
);

   logic unused_w;
   assign unused_w = ^ctl_wdata;

   // R1
   idle_cs_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !ctl_rdata[0] |-> spi_cs_n);

   // R2
   req_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
      spi_req |-> !spi_cs_n);

   // R10
   busy_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ctl_rdata[0] && ctl_we) |=> (ctl_rdata[9:1] == $past(ctl_rdata[9:1])));

   // R11
   clr_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ctl_we && !ctl_rdata[0] && ctl_wdata[12]) |=> !ctl_rdata[12]);

   // R12
   go_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ctl_rdata[0]) |-> $past(ctl_we && ctl_wdata[0]));

   // R7
   done_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ctl_rdata[12]) |-> !$rose(ctl_rdata[13]));

endmodule

bind flash_cycle_engine fce_chk u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .ctl_we    (ctl_we),
   .ctl_wdata (ctl_wdata),
   .ctl_rdata (ctl_rdata),
   .spi_cs_n  (spi_cs_n),
   .spi_req   (spi_req)
);

// File: tb/flash_cycle_engine_test.sv
`timescale 1ns/1ps
module flash_cycle_engine_test;

   localparam int PM = 4;
   localparam int NV = 15;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        addr_we = 1'b0;
   logic [23:0] addr_wdata = '0;
   logic [23:0] prot_lo = 24'h010000;
   logic [23:0] prot_hi = 24'h01FFFF;
   logic        fifo_we = 1'b0;
   logic [5:0]  fifo_widx = '0;
   logic [7:0]  fifo_wdata = '0;
   logic [5:0]  fifo_ridx = '0;
   logic [7:0]  fifo_rdata;
   logic        ctl_we = 1'b0;
   logic [15:0] ctl_wdata = '0;
   logic [15:0] ctl_rdata;
   logic        spi_cs_n, spi_req;
   logic [7:0]  spi_tx;
   logic        spi_ack = 1'b0;
   logic [7:0]  spi_rx = '0;

   always #2.5 clk = ~clk;

   flash_cycle_engine #(.ADDR_W(24), .FIFO_DEPTH(64), .POLL_MAX(PM)) uut (
      .clk(clk), .rst_n(rst_n), .addr_we(addr_we), .addr_wdata(addr_wdata),
      .prot_lo(prot_lo), .prot_hi(prot_hi), .fifo_we(fifo_we),
      .fifo_widx(fifo_widx), .fifo_wdata(fifo_wdata), .fifo_ridx(fifo_ridx),
      .fifo_rdata(fifo_rdata), .ctl_we(ctl_we), .ctl_wdata(ctl_wdata),
      .ctl_rdata(ctl_rdata), .spi_cs_n(spi_cs_n), .spi_req(spi_req),
      .spi_tx(spi_tx), .spi_ack(spi_ack), .spi_rx(spi_rx)
   );

   int nchk = 0;
   int nfail = 0;
   int cyc = 0;

   // flash / shifter model state (written only by the model)
   logic [7:0] logtx [2048];
   int logn = 0;
   int nframes = 0;
   int sreads = 0;
   int kb = 0;
   logic [7:0] fop = '0;
   logic prev_cs = 1'b1;
   // written only by the stimulus
   int sbase = 0;
   int busy_target = 0;

   logic [7:0] expb [256];
   int expn, expf;

   function automatic logic [7:0] pat(input int k);
      return 8'(k * 7 + 3);
   endfunction

   always @(negedge clk) begin
      logic [7:0] r;
      if (!rst_n) begin
         spi_ack <= 1'b0;
         prev_cs = 1'b1;
      end else begin
         if (prev_cs && !spi_cs_n) begin
            nframes++;
            kb = 0;
         end
         prev_cs = spi_cs_n;
         if (spi_ack) begin
            spi_ack <= 1'b0;
         end else if (spi_req) begin
            r = 8'h00;
            if (kb == 0) fop = spi_tx;
            else if (fop == 8'h05) begin
               r = ((sreads - sbase) < busy_target) ? 8'h41 : 8'h40;
               sreads++;
            end else if (fop == 8'h0B || fop == 8'h9F) r = pat(kb);
            logtx[logn] = spi_tx;
            logn++;
            kb++;
            spi_rx  <= r;
            spi_ack <= 1'b1;
         end
      end
   end

   always @(posedge clk) begin
      cyc++;
      if (cyc == 150000) begin
         nchk++;
         nfail++;
         $display("FAIL watchdog actual=%0d expected<%0d", cyc, 150000);
         $display("%0d/%0d checks passed", nchk - nfail, nchk);
         $finish;
      end
   end

   task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
      nchk++;
      if (!ok) begin
         nfail++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic wr_ctl(input logic [15:0] v);
      @(negedge clk); ctl_we = 1'b1; ctl_wdata = v;
      @(negedge clk); ctl_we = 1'b0;
   endtask

   task automatic wr_addr(input logic [23:0] a);
      @(negedge clk); addr_we = 1'b1; addr_wdata = a;
      @(negedge clk); addr_we = 1'b0;
   endtask

   task automatic wr_fifo(input int i, input logic [7:0] d);
      @(negedge clk); fifo_we = 1'b1; fifo_widx = 6'(i); fifo_wdata = d;
      @(negedge clk); fifo_we = 1'b0;
   endtask

   task automatic wait_idle();
      int n = 0;
      do begin @(negedge clk); n++; end while (ctl_rdata[0] && n < 5000);
   endtask

   function automatic string tag_of(input logic [2:0] code, input logic [2:0] st);
      if (st[2])      return "R8";
      if (code >= 6)  return "R9";
      if (st[1])      return "R7";
      case (code)
         3'd0: return "R2";
         3'd1: return "R3";
         3'd2: return "R4";
         default: return "R5";
      endcase
   endfunction

   task automatic run_vec(input logic [2:0] code, input logic [23:0] addr,
                          input logic [5:0] lenm1, input int polls,
                          input logic [2:0] st, input bit mid_write);
      int lb, fb, bad, nreads;
      bit wr_class, skip;
      logic [7:0] opc;
      string tg;
      tg = tag_of(code, st);
      for (int i = 0; i < 64; i++) wr_fifo(i, 8'hC0 ^ 8'(i));
      wr_addr(addr);
      lb = logn;
      fb = nframes;
      sbase = sreads;
      busy_target = polls;
      wr_ctl({1'b0, 3'b111, 2'b00, lenm1, code, 1'b1});
      if (mid_write) begin
         repeat (6) @(negedge clk);
         chk(ctl_rdata[0] == 1'b1, "R10 busy", ctl_rdata[0], 1);
         wr_addr(24'hFFFFFF);
         wr_ctl({1'b0, 3'b111, 2'b00, 6'd9, 3'd2, 1'b1});
      end
      wait_idle();
      // expected stream built from the requirement text
      wr_class = (code == 3'd1 || code == 3'd2 || code == 3'd4);
      skip = st[2] || (code >= 3'd6);
      expn = 0; expf = 0;
      case (code)
         3'd0: opc = 8'h0B;  3'd1: opc = 8'h02;  3'd2: opc = 8'h20;
         3'd3: opc = 8'h9F;  3'd4: opc = 8'h01;  default: opc = 8'h05;
      endcase
      nreads = (polls + 1 > PM) ? PM : polls + 1;
      if (!skip) begin
         if (wr_class) begin expb[expn++] = 8'h06; expf++; end
         expb[expn++] = opc; expf++;
         if (code <= 3'd2) begin
            expb[expn++] = addr[23:16];
            expb[expn++] = addr[15:8];
            expb[expn++] = addr[7:0];
         end
         if (code == 3'd0) expb[expn++] = 8'h00;
         if (code == 3'd0 || code == 3'd3 || code == 3'd5)
            for (int i = 0; i <= int'(lenm1); i++) expb[expn++] = 8'h00;
         if (code == 3'd1 || code == 3'd4)
            for (int i = 0; i <= int'(lenm1); i++) expb[expn++] = 8'hC0 ^ 8'(i);
         if (wr_class)
            for (int i = 0; i < nreads; i++) begin
               expb[expn++] = 8'h05; expb[expn++] = 8'h00; expf++;
            end
      end
      bad = 0;
      if (logn - lb != expn) bad = 1;
      else for (int i = 0; i < expn; i++) if (logtx[lb + i] != expb[i]) bad++;
      chk(bad == 0, {tg, " bytes"}, logn - lb, expn);
      chk(nframes - fb == expf, {tg, " frames"}, nframes - fb, expf);
      chk(ctl_rdata[14:12] == st, {tg, " R11 status"}, ctl_rdata[14:12], st);
      chk(ctl_rdata[9:1] == {lenm1, code}, "R12 fields", ctl_rdata[9:1], {lenm1, code});
      if (wr_class && !skip)
         chk(nframes - fb - 2 == nreads, "R6 polls", nframes - fb - 2, nreads);
      if (!skip && (code == 3'd0 || code == 3'd3 || code == 3'd5)) begin
         bad = 0;
         for (int i = 0; i <= int'(lenm1); i++) begin
            logic [7:0] e;
            fifo_ridx = 6'(i);
            #1;
            e = (code == 3'd0) ? pat(5 + i) : (code == 3'd3) ? pat(1 + i) : 8'h40;
            if (fifo_rdata != e) bad++;
         end
         chk(bad == 0, {tg, " rdata"}, bad, 0);
      end
   endtask

   // {code, addr, len-1, busy polls, expected {aerr,cerr,done}}
   localparam logic [39:0] VT [NV] = '{
      {3'd0, 24'h123456, 6'd3,  4'd0, 3'b001},
      {3'd0, 24'h000010, 6'd63, 4'd0, 3'b001},
      {3'd1, 24'h020000, 6'd7,  4'd2, 3'b001},
      {3'd2, 24'h0FF000, 6'd5,  4'd1, 3'b001},
      {3'd3, 24'h000000, 6'd2,  4'd0, 3'b001},
      {3'd4, 24'h000000, 6'd0,  4'd0, 3'b001},
      {3'd5, 24'h000000, 6'd1,  4'd0, 3'b001},
      {3'd1, 24'h010000, 6'd3,  4'd0, 3'b100},
      {3'd2, 24'h01FFFF, 6'd0,  4'd0, 3'b100},
      {3'd2, 24'h020000, 6'd0,  4'd0, 3'b001},
      {3'd1, 24'h030000, 6'd1,  4'd4, 3'b010},
      {3'd6, 24'h000000, 6'd0,  4'd0, 3'b010},
      {3'd7, 24'h000000, 6'd0,  4'd0, 3'b010},
      {3'd2, 24'h00F000, 6'd0,  4'd3, 3'b001},
      {3'd1, 24'h00FFFF, 6'd0,  4'd0, 3'b001}
   };

   initial begin
      repeat (4) @(negedge clk);
      chk(ctl_rdata == 16'h0000, "R1 ctl", ctl_rdata, 0);
      chk(spi_cs_n == 1'b1 && spi_req == 1'b0, "R1 spi", {spi_cs_n, spi_req}, 2'b10);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      chk(ctl_rdata == 16'h0000, "R1 after release", ctl_rdata, 0);

      for (int v = 0; v < NV; v++)
         run_vec(VT[v][39:37], VT[v][36:13], VT[v][12:7], int'(VT[v][6:3]), VT[v][2:0], 1'b0);

      // R10: program with a go and an address write issued mid-cycle
      run_vec(3'd1, 24'h040000, 6'd3, 3, 3'b001, 1'b1);

      // R11: status persists without a clear bit, then clears on write-1
      begin
         int lb;
         lb = logn;
         wr_ctl(16'h0000);
         chk(ctl_rdata[12] == 1'b1, "R11 hold", ctl_rdata[12], 1);
         wr_ctl(16'h1000);
         repeat (3) @(negedge clk);
         chk(ctl_rdata[14:12] == 3'b000, "R11 clear", ctl_rdata[14:12], 0);
         chk(logn == lb && ctl_rdata[0] == 1'b0, "R11 no cycle", logn - lb, 0);
      end

      $display("%0d/%0d checks passed", nchk - nfail, nchk);
      $finish;
   end

endmodule